// File: doc/BRIEF.md
# Quadrature Decoder with Edge Timestamps

This block turns a pair of encoder signals that are a quarter period out of phase into a free-running 16-bit position count. It counts every valid edge on either channel, which gives four counts per encoder cycle. Each counted edge moves the count up or down by one, depending on which channel leads. Both inputs first cross into the local clock domain through a chain of synchronizer flops. A transition in which both channels change together cannot be placed in the sequence, so the block reports it and does not count it.

At each counted edge the block latches the value of an external free-running timebase. The latched value is a timestamp for the latest edge. The block also presents a registered copy of the live timebase. From the gap between the two, the host can interpolate position between counts when the shaft turns slowly. The host may overwrite the position at any time. A one-cycle wrap pulse marks every overflow or underflow of the count.

Top module: `quad_decoder`

## Requirements
- R1: During and right after reset, pos_o, stamp_o, dir_o, wrap_irq_o and err_o are all zero.
- R2: A change on enc_a_i/enc_b_i reaches pos_o on the third rising clock edge after it is applied. Two of those edges are synchronizer flops and one is the position register. Before that edge, pos_o is unchanged.
- R3: Write the channel pair as {A,B}. The forward sequence 00→10→11→01→00 (A leads) raises pos_o by one per transition and sets dir_o to 1.
- R4: The reverse sequence 00→01→11→10→00 (B leads) lowers pos_o by one per transition and sets dir_o to 0.
- R5: A forward transition while pos_o is 0xFFFF gives 0x0000, and wrap_irq_o is high for exactly one cycle.
- R6: A reverse transition while pos_o is 0x0000 gives 0xFFFF, and wrap_irq_o is high for exactly one cycle.
- R7: On every counted transition, stamp_o takes the value timebase_i had at the clock edge that updates pos_o.
- R8: If both channels change at once, pos_o, dir_o and stamp_o keep their values and err_o is high for one cycle.
- R9: When wr_en_i is high at a clock edge, pos_o takes wr_pos_i at that edge. This overrides any count update at the same edge, and wrap_irq_o stays low.
- R10: timebase_o equals timebase_i delayed by one clock.
- R11: While the channels are steady, pos_o, dir_o and stamp_o do not change, and wrap_irq_o and err_o stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a_i | input | 1 | Encoder channel A (asynchronous) |
| enc_b_i | input | 1 | Encoder channel B (asynchronous) |
| timebase_i | input | 16 | Free-running timebase |
| wr_en_i | input | 1 | Host write strobe for the position |
| wr_pos_i | input | 16 | Position value to load |
| pos_o | output | 16 | Current position count |
| stamp_o | output | 16 | Timebase value at the last counted edge |
| timebase_o | output | 16 | Registered live timebase |
| dir_o | output | 1 | 1 if the last counted edge was forward |
| wrap_irq_o | output | 1 | One-cycle pulse on overflow or underflow |
| err_o | output | 1 | One-cycle pulse on a simultaneous two-channel change |

## Verification
Some behaviour holds on every clock and is checked by assertions:
- Without a host write, the position moves by at most one.
- A wrap pulse only appears at the 0xFFFF/0x0000 boundary.
- An error cycle never moves the count.
- A host write always lands, and it never raises a wrap pulse.

Other behaviour needs scenarios driven by the bench:
- The three-edge latency through the synchronizer.
- The direction of each quadrature sequence.
- That the timestamp matches the timebase at the update edge.
- The collision between a host write and a count.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    // Position of a {A,B} pair in the forward cycle 00,10,11,01.
    function automatic logic [1:0] phase_of(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[ch]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign dout[ch] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/qdec_step.sv
module qdec_step
    import qdec_pkg::*;
(
    input  logic [1:0] prev_ab,
    input  logic [1:0] curr_ab,
    output step_e      step
);
    logic [1:0] delta;

    always_comb begin
        delta = phase_of(curr_ab) - phase_of(prev_ab);
        unique case (delta)
            2'd0:    step = STEP_HOLD;
            2'd1:    step = STEP_UP;
            2'd3:    step = STEP_DOWN;
            default: step = STEP_BAD;
        endcase
    end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int W = 16
) (
    input  step_e        step,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        case (step)
            STEP_UP: begin
                nxt  = cur + ONE;
                wrap = &cur;
            end
            STEP_DOWN: begin
                nxt  = cur - ONE;
                wrap = ~|cur;
            end
            default: ;
        endcase
        if (wr_en) begin
            nxt  = wr_val;
            wrap = 1'b0;
        end
    end
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
    import qdec_pkg::*;
#(
    parameter int POS_W       = 16,
    parameter int TB_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    input  logic [TB_W-1:0]  timebase_i,
    input  logic             wr_en_i,
    input  logic [POS_W-1:0] wr_pos_i,
    output logic [POS_W-1:0] pos_o,
    output logic [TB_W-1:0]  stamp_o,
    output logic [TB_W-1:0]  timebase_o,
    output logic             dir_o,
    output logic             wrap_irq_o,
    output logic             err_o
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [TB_W-1:0]  stamp;
        logic [TB_W-1:0]  tb;
        logic [1:0]       ab;
        logic             dir;
        logic             wrap;
        logic             err;
    } state_t;

    state_t           st_d, st_q;
    logic [1:0]       ab_sync;
    step_e            step;
    logic [POS_W-1:0] pos_nxt;
    logic             wrap_nxt;

    qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_a_i, enc_b_i}),
        .dout (ab_sync)
    );

    qdec_step u_step (
        .prev_ab(st_q.ab),
        .curr_ab(ab_sync),
        .step   (step)
    );

    qdec_counter #(.W(POS_W)) u_cnt (
        .step  (step),
        .wr_en (wr_en_i),
        .wr_val(wr_pos_i),
        .cur   (st_q.pos),
        .nxt   (pos_nxt),
        .wrap  (wrap_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ab   = ab_sync;
        st_d.tb   = timebase_i;
        st_d.pos  = pos_nxt;
        st_d.wrap = wrap_nxt;
        st_d.err  = (step == STEP_BAD);
        if (step == STEP_UP || step == STEP_DOWN) begin
            st_d.dir   = (step == STEP_UP);
            st_d.stamp = timebase_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o      = st_q.pos;
    assign stamp_o    = st_q.stamp;
    assign timebase_o = st_q.tb;
    assign dir_o      = st_q.dir;
    assign wrap_irq_o = st_q.wrap;
    assign err_o      = st_q.err;

    // R3 / R4: without a host write the count moves by at most one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> (pos_o == $past(pos_o) ||
                             pos_o == $past(pos_o) + POS_ONE ||
                             pos_o == $past(pos_o) - POS_ONE));

    // R5 / R6: a wrap pulse only at the numeric boundary
    a_r5_wrap_edge: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq_o |-> ((pos_o == '0 && $past(pos_o) == POS_MAX) ||
                        (pos_o == POS_MAX && $past(pos_o) == '0)));

    // R8: an invalid transition leaves the count alone
    a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !$past(wr_en_i)) |-> (pos_o == $past(pos_o)));

    // R8: error and wrap never coincide
    a_r8_err_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && wrap_irq_o));

    // R9: host write always lands and never raises a wrap pulse
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en_i) |-> (pos_o == $past(wr_pos_i) && !wrap_irq_o));

    // R10: live timebase is a one-cycle copy
    a_r10_tb_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> timebase_o == $past(timebase_i));
endmodule

// File: tb/quad_decoder_tb.sv
`timescale 1ns/1ps
module quad_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a_i = 1'b0, enc_b_i = 1'b0;
    logic [15:0] timebase_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_pos_i = '0;
    logic [15:0] pos_o, stamp_o, timebase_o;
    logic        dir_o, wrap_irq_o, err_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_pos = '0, m_stamp = '0;
    logic        m_dir = 1'b0;
    logic [1:0]  m_ab = 2'b00;

    always #2.5 clk = ~clk;

    quad_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a_i(enc_a_i), .enc_b_i(enc_b_i),
        .timebase_i(timebase_i), .wr_en_i(wr_en_i), .wr_pos_i(wr_pos_i),
        .pos_o(pos_o), .stamp_o(stamp_o), .timebase_o(timebase_o),
        .dir_o(dir_o), .wrap_irq_o(wrap_irq_o), .err_o(err_o)
    );

    function automatic logic [1:0] fwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply a new channel pair; optionally collide a host write with the update edge.
    task automatic step(input logic [1:0] nab, input logic [15:0] tb,
                        input bit do_wr, input logic [15:0] wv, input string req);
        logic        up, dn, bad, wr_exp;
        logic [15:0] exp_pos;
        logic        exp_wrap;
        up  = (nab == fwd(m_ab));
        dn  = (nab == rev(m_ab));
        bad = (nab == ~m_ab);
        exp_pos = m_pos; exp_wrap = 1'b0;
        if (up) begin exp_wrap = (m_pos == 16'hFFFF); exp_pos = m_pos + 16'd1; end
        if (dn) begin exp_wrap = (m_pos == 16'h0000); exp_pos = m_pos - 16'd1; end
        if (do_wr) begin exp_pos = wv; exp_wrap = 1'b0; end
        @(negedge clk);
        {enc_a_i, enc_b_i} = nab;
        timebase_i = tb;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R2 latency", pos_o, m_pos);
        wr_en_i = do_wr; wr_pos_i = wv;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
        wr_exp = 1'b0;
        if (up || dn) begin m_dir = up; m_stamp = tb; end
        m_pos = exp_pos;
        m_ab = nab;
        check({req, " pos"}, pos_o, m_pos);
        check({req, " dir"}, dir_o, m_dir);
        check("R7 stamp", stamp_o, m_stamp);
        check({req, " wrap"}, wrap_irq_o, exp_wrap);
        check("R8 err", err_o, bad);
        check("R10 tb", timebase_o, tb);
        if (exp_wrap) begin
            @(negedge clk);
            check({req, " wrap one cycle"}, wrap_irq_o, wr_exp);
        end
    endtask

    task automatic host_write(input logic [15:0] v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_pos_i = v;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
        m_pos = v;
        check("R9 write", pos_o, v);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 pos", pos_o, 0);
        check("R1 stamp", stamp_o, 0);
        check("R1 dir", dir_o, 0);
        check("R1 wrap", wrap_irq_o, 0);
        check("R1 err", err_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pos after", pos_o, 0);

        // forward and reverse full cycles
        for (int i = 0; i < 4; i++) step(fwd(m_ab), 16'h0100 + 16'(i), 1'b0, '0, "R3");
        for (int i = 0; i < 4; i++) step(rev(m_ab), 16'h0200 + 16'(i), 1'b0, '0, "R4");

        // overflow and underflow
        host_write(16'hFFFE);
        for (int i = 0; i < 3; i++) step(fwd(m_ab), 16'h0300 + 16'(i), 1'b0, '0, "R5");
        host_write(16'h0001);
        for (int i = 0; i < 3; i++) step(rev(m_ab), 16'h0400 + 16'(i), 1'b0, '0, "R6");

        // both channels flip together
        step(~m_ab, 16'h0500, 1'b0, '0, "R8");

        // host write colliding with a count at the wrap boundary
        host_write(16'hFFFF);
        step(fwd(m_ab), 16'h0600, 1'b1, 16'h1234, "R9");

        // steady inputs
        begin
            logic [15:0] p0, s0;
            logic        d0;
            p0 = pos_o; s0 = stamp_o; d0 = dir_o;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                timebase_i = 16'(i * 77);
                check("R11 pos", pos_o, p0);
                check("R11 stamp", stamp_o, s0);
                check("R11 dir", dir_o, d0);
                check("R11 wrap", wrap_irq_o, 0);
                check("R11 err", err_o, 0);
            end
            // R10 directed: new timebase shows after one edge
            @(negedge clk);
            timebase_i = 16'hBEEF;
            check("R10 before", timebase_o, 16'(5 * 77));
            @(negedge clk);
            check("R10 after", timebase_o, 16'hBEEF);
        end

        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [1:0] nab;
            r = $urandom_range(0, 99);
            if (r < 45)      nab = fwd(m_ab);
            else if (r < 85) nab = rev(m_ab);
            else if (r < 93) nab = m_ab;
            else             nab = ~m_ab;
            step(nab, 16'($urandom), ($urandom_range(0, 19) == 0), 16'($urandom), "R3/R4 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule